// File: doc/BRIEF.md
# Horizontal Drive Pulse Generator

This block produces the pulse that drives a display's horizontal deflection output stage. It takes two inputs from the line timing logic: a one-cycle start-of-line strobe, for example from a digital PLL, and the measured line period in clock cycles. It runs a line counter and places an active-low drive pulse inside each line. One 8-bit code sets the pulse length as a share of the line. A second 8-bit code moves the pulse start ahead of or behind the line reference. If strobes stop arriving, the counter keeps running at the last captured period.

The output transistor conducts while the drive output is low, so high is the safe level. Three protection inputs force the safe level:
- An active-low enable. Its effect is unlatched.
- An undervoltage flag. Its effect is unlatched.
- An overvoltage shutdown flag. It latches the drive off and also latches a video mute output low. Only reset clears this latch.

The period, duty code and phase code are captured only at a line boundary. A pulse that is already under way is therefore never cut short or stretched by a code change.

Top module: `hdrive_gen`

## Requirements
- R1: During and after reset, `hdrive` is high and `mute_n` is high. No pulse is produced until a line boundary has captured a nonzero period.
- R2: With captured period P, the captured duty length L and the captured start S, `hdrive` is low for exactly L consecutive counter values. These values start at counter value S and wrap modulo P. `hdrive` reflects counter value n one clock edge after the counter holds n. The counter is 0 in the cycle after a boundary.
- R3: The duty code is clamped to the range 77..179 and then taken as a fraction of 256. The length is L = floor(P*clamped/256). Code 128 gives half the line, and codes below 77 or above 179 give the 30 % and 70 % limits.
- R4: The phase code is first clamped to at most 128. Code 38 means zero offset. For code c >= 38 the start is S = floor(P*(c-38)/256). For c < 38 the pulse leads, with S = P - floor(P*(38-c)/256), and S = P becomes 0. The offset range is therefore -38/256 to +90/256 of a line.
- R5: The period, duty code and phase code are captured only at a line boundary. A change between boundaries has no effect on `hdrive` until the next boundary.
- R6: A line boundary occurs when `line_strobe` is high, or when the counter reaches P-1 with P nonzero. Without strobes, the pulse pattern therefore repeats every P cycles.
- R7: A strobe arriving mid-line restarts the counter at 0 on the next edge and captures new codes.
- R8: While `drive_en_n` is high, `hdrive` is high one edge later. Normal pulsing resumes one edge after it returns low.
- R9: While `uv_flag` is high, `hdrive` is high one edge later. The effect is not latched.
- R10: One edge after `ov_flag` is high, `hdrive` stays high and `mute_n` stays low until reset, whatever the other inputs do.
- R11: A captured period of 0 produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| line_strobe | input | 1 | One-cycle start-of-line reference |
| line_period | input | CNT_W (12) | Measured line period in clock cycles |
| duty_code | input | CODE_W (8) | Drive low-time code |
| phase_code | input | CODE_W (8) | Pulse start offset code |
| drive_en_n | input | 1 | Active-low drive enable |
| uv_flag | input | 1 | Undervoltage indication, unlatched block |
| ov_flag | input | 1 | Overvoltage shutdown request, latched |
| hdrive | output | 1 | Horizontal drive; low turns the output transistor on |
| mute_n | output | 1 | Active-low video mute, latched by overvoltage |

## Verification
Every output is registered once. The drive level for counter value n, and the effect of an enable, undervoltage or overvoltage input, both appear one clock edge after the cycle that holds them. A new period or code takes effect on the edge after the boundary that captured it, so the first affected output follows one edge after that. The bench steps a cycle model on each rising edge with the same inputs the design samples. It then compares both outputs at the following falling edge, so every comparison lands exactly on the cycle in which the result is due.

// File: rtl/hdg_pkg.sv
package hdg_pkg;
  // Boundary cause, kept for readability of the line timer
  typedef enum logic [1:0] {
    BND_NONE  = 2'd0,
    BND_STROBE = 2'd1,
    BND_WRAP  = 2'd2
  } bnd_e;

  // Captured per-line settings
  typedef struct packed {
    logic [11:0] period;
    logic [7:0]  duty;
    logic [7:0]  phase;
  } line_cfg_t;
endpackage

// File: rtl/hdg_line_timer.sv
module hdg_line_timer #(
  parameter int CNT_W  = 12,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_strobe,
  input  logic [CNT_W-1:0]  line_period,
  input  logic [CODE_W-1:0] duty_code,
  input  logic [CODE_W-1:0] phase_code,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  per_q,
  output logic [CODE_W-1:0] duty_q,
  output logic [CODE_W-1:0] phase_q
);
  import hdg_pkg::*;

  bnd_e              bnd;
  logic [CNT_W-1:0]  cnt_d, per_d;
  logic [CODE_W-1:0] duty_d, phase_d;
  logic              cfg_en;

  // Boundary detection: strobe wins over self wrap
  always_comb begin
    if (line_strobe)
      bnd = BND_STROBE;
    else if ((per_q != '0) && (cnt == per_q - CNT_W'(1)))
      bnd = BND_WRAP;
    else
      bnd = BND_NONE;
  end

  // Next state
  always_comb begin
    cfg_en  = (bnd != BND_NONE);
    cnt_d   = cfg_en ? '0 : cnt + CNT_W'(1);
    per_d   = line_period;
    duty_d  = duty_code;
    phase_d = phase_code;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      per_q   <= '0;
      duty_q  <= '0;
      phase_q <= '0;
    end else begin
      cnt <= cnt_d;
      if (cfg_en) begin
        per_q   <= per_d;
        duty_q  <= duty_d;
        phase_q <= phase_d;
      end
    end
  end
endmodule

// File: rtl/hdg_window.sv
module hdg_window #(
  parameter int CNT_W   = 12,
  parameter int CODE_W  = 8,
  parameter int DUTY_LO = 77,
  parameter int DUTY_HI = 179,
  parameter int PH_ZERO = 38,
  parameter int PH_MAX  = 128
) (
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  per,
  input  logic [CODE_W-1:0] duty,
  input  logic [CODE_W-1:0] phase,
  output logic              active
);
  localparam int PROD_W = CNT_W + CODE_W;

  logic [CODE_W-1:0] duty_c, phase_c, mag;
  logic              lead;
  logic [PROD_W-1:0] len_prod, ph_prod;
  logic [CNT_W-1:0]  low_len, shift;
  logic [CNT_W:0]    start_raw, end_raw;
  logic [CNT_W-1:0]  start_v, end_v;

  always_comb begin
    // Duty clamp and scale
    if (duty < CODE_W'(DUTY_LO))
      duty_c = CODE_W'(DUTY_LO);
    else if (duty > CODE_W'(DUTY_HI))
      duty_c = CODE_W'(DUTY_HI);
    else
      duty_c = duty;
    len_prod = PROD_W'(per) * PROD_W'(duty_c);
    low_len  = len_prod[PROD_W-1:CODE_W];

    // Phase clamp, sign split, scale
    phase_c = (phase > CODE_W'(PH_MAX)) ? CODE_W'(PH_MAX) : phase;
    lead    = (phase_c < CODE_W'(PH_ZERO));
    mag     = lead ? (CODE_W'(PH_ZERO) - phase_c) : (phase_c - CODE_W'(PH_ZERO));
    ph_prod = PROD_W'(per) * PROD_W'(mag);
    shift   = ph_prod[PROD_W-1:CODE_W];

    // Start modulo period
    start_raw = lead ? ({1'b0, per} - {1'b0, shift}) : {1'b0, shift};
    if (start_raw >= {1'b0, per})
      start_raw = start_raw - {1'b0, per};
    start_v = start_raw[CNT_W-1:0];

    // End modulo period
    end_raw = {1'b0, start_v} + {1'b0, low_len};
    if (end_raw >= {1'b0, per})
      end_raw = end_raw - {1'b0, per};
    end_v = end_raw[CNT_W-1:0];

    // Window membership, possibly wrapping past the line end
    if (per == '0)
      active = 1'b0;
    else if (start_v <= end_v)
      active = (cnt >= start_v) && (cnt < end_v);
    else
      active = (cnt >= start_v) || (cnt < end_v);
  end
endmodule

// File: rtl/hdg_guard.sv
module hdg_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic drive_en_n,
  input  logic uv_flag,
  input  logic ov_flag,
  output logic hdrive,
  output logic mute_n
);
  logic ov_lat, ov_lat_d, hdrive_d, allow;

  always_comb begin
    ov_lat_d = ov_lat | ov_flag;
    allow    = ~drive_en_n & ~uv_flag & ~ov_flag & ~ov_lat;
    hdrive_d = ~(active & allow);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_lat <= 1'b0;
      hdrive <= 1'b1;
    end else begin
      ov_lat <= ov_lat_d;
      hdrive <= hdrive_d;
    end
  end

  assign mute_n = ~ov_lat;
endmodule

// File: rtl/hdrive_gen.sv
module hdrive_gen #(
  parameter int CNT_W   = 12,
  parameter int CODE_W  = 8,
  parameter int DUTY_LO = 77,
  parameter int DUTY_HI = 179,
  parameter int PH_ZERO = 38,
  parameter int PH_MAX  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_strobe,
  input  logic [CNT_W-1:0]  line_period,
  input  logic [CODE_W-1:0] duty_code,
  input  logic [CODE_W-1:0] phase_code,
  input  logic              drive_en_n,
  input  logic              uv_flag,
  input  logic              ov_flag,
  output logic              hdrive,
  output logic              mute_n
);
  logic [CNT_W-1:0]  cnt, per_q;
  logic [CODE_W-1:0] duty_q, phase_q;
  logic              active;

  hdg_line_timer #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe),
    .line_period(line_period), .duty_code(duty_code), .phase_code(phase_code),
    .cnt(cnt), .per_q(per_q), .duty_q(duty_q), .phase_q(phase_q)
  );

  hdg_window #(
    .CNT_W(CNT_W), .CODE_W(CODE_W), .DUTY_LO(DUTY_LO), .DUTY_HI(DUTY_HI),
    .PH_ZERO(PH_ZERO), .PH_MAX(PH_MAX)
  ) u_window (
    .cnt(cnt), .per(per_q), .duty(duty_q), .phase(phase_q), .active(active)
  );

  hdg_guard u_guard (
    .clk(clk), .rst_n(rst_n), .active(active), .drive_en_n(drive_en_n),
    .uv_flag(uv_flag), .ov_flag(ov_flag), .hdrive(hdrive), .mute_n(mute_n)
  );
endmodule

// File: rtl/hdrive_gen_chk.sv
module hdrive_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic drive_en_n,
  input logic uv_flag,
  input logic ov_flag,
  input logic hdrive,
  input logic mute_n
);
  // R8
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en_n |=> hdrive);
  // R9
  uv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flag |=> hdrive);
  // R10
  ov_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ov_flag |=> (hdrive && !mute_n));
  // R10
  mute_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mute_n |=> (!mute_n && hdrive));
  // R10
  mute_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mute_n) |-> $past(ov_flag));
endmodule

bind hdrive_gen hdrive_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .drive_en_n(drive_en_n), .uv_flag(uv_flag),
  .ov_flag(ov_flag), .hdrive(hdrive), .mute_n(mute_n)
);

// File: tb/hdrive_gen_tb.sv
`timescale 1ns/1ps
module hdrive_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_strobe = 1'b0;
  logic [11:0] line_period = '0;
  logic [7:0]  duty_code = '0;
  logic [7:0]  phase_code = '0;
  logic        drive_en_n = 1'b0;
  logic        uv_flag = 1'b0;
  logic        ov_flag = 1'b0;
  logic        hdrive, mute_n;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  // model state
  logic [11:0] m_cnt = '0;
  int m_per = 0, m_duty = 0, m_phase = 0;
  bit m_ov = 0, exp_h = 1, exp_m = 1;
  int unsigned seed_v;

  always #2 clk = ~clk;

  hdrive_gen u_dut (
    .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe), .line_period(line_period),
    .duty_code(duty_code), .phase_code(phase_code), .drive_en_n(drive_en_n),
    .uv_flag(uv_flag), .ov_flag(ov_flag), .hdrive(hdrive), .mute_n(mute_n)
  );

  // R2/R3/R4/R11: is counter value c inside the low window
  function automatic bit in_pulse(int c, int p, int d, int ph);
    int dc, pc, len, st;
    if (p == 0) return 0;
    dc  = (d < 77) ? 77 : ((d > 179) ? 179 : d);
    len = (p * dc) / 256;
    pc  = (ph > 128) ? 128 : ph;
    if (pc >= 38) st = (p * (pc - 38)) / 256;
    else          st = p - (p * (38 - pc)) / 256;
    if (st >= p) st = st - p;
    return ((((c - st) % p) + p) % p) < len;
  endfunction

  task automatic tick();
    bit act, bnd;
    @(posedge clk);
    if (!rst_n) begin
      m_cnt = '0; m_per = 0; m_duty = 0; m_phase = 0;
      m_ov = 0; exp_h = 1; exp_m = 1;
    end else begin
      act   = in_pulse(int'(m_cnt), m_per, m_duty, m_phase);
      exp_h = !(act && !drive_en_n && !uv_flag && !ov_flag && !m_ov);
      m_ov  = m_ov | ov_flag;
      exp_m = !m_ov;
      bnd   = line_strobe || (m_per != 0 && int'(m_cnt) == m_per - 1);
      if (bnd) begin
        m_cnt = '0; m_per = int'(line_period);
        m_duty = int'(duty_code); m_phase = int'(phase_code);
      end else begin
        m_cnt = m_cnt + 12'd1;
      end
    end
    @(negedge clk);
    checks++;
    if (hdrive !== exp_h) begin
      errors++;
      $display("FAIL %s hdrive actual=%b expected=%b at %0t", tag, hdrive, exp_h, $time);
    end
    checks++;
    if (mute_n !== exp_m) begin
      errors++;
      $display("FAIL %s mute_n actual=%b expected=%b at %0t", tag, mute_n, exp_m, $time);
    end
  endtask

  // one line of n cycles starting with a strobe
  task automatic run_line(int p, int d, int ph, int n);
    line_period = 12'(p); duty_code = 8'(d); phase_code = 8'(ph);
    line_strobe = 1'b1;
    tick();
    line_strobe = 1'b0;
    for (int i = 1; i < n; i++) tick();
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    seed_v = $urandom(32'h5eed_1291);
    tag = "R1";
    for (int i = 0; i < 4; i++) tick();
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) tick();   // R1: idle before any boundary

    tag = "R2"; run_line(100, 128, 38, 100); run_line(100, 128, 38, 100);
    tag = "R3"; run_line(100, 0, 38, 100); run_line(100, 255, 38, 100);
    run_line(64, 77, 38, 64); run_line(64, 179, 38, 64);
    tag = "R4"; run_line(100, 128, 0, 100); run_line(100, 128, 200, 100);
    run_line(100, 150, 90, 100); run_line(57, 128, 37, 57);
    // R5: codes change mid-line, no strobe; effect only after wrap
    tag = "R5";
    run_line(80, 100, 38, 40);
    duty_code = 8'd170; phase_code = 8'd100; line_period = 12'd50;
    for (int i = 0; i < 40 + 100; i++) tick();
    // R6: flywheel without strobes
    tag = "R6";
    for (int i = 0; i < 200; i++) tick();
    // R7: early strobe
    tag = "R7"; run_line(120, 128, 60, 30); run_line(90, 90, 10, 90);
    // R11: zero period
    tag = "R11"; run_line(0, 128, 38, 80);
    // R8 / R9
    tag = "R8"; run_line(100, 128, 38, 20);
    drive_en_n = 1'b1; for (int i = 0; i < 30; i++) tick();
    drive_en_n = 1'b0; for (int i = 0; i < 80; i++) tick();
    tag = "R9"; run_line(100, 128, 38, 20);
    uv_flag = 1'b1; for (int i = 0; i < 30; i++) tick();
    uv_flag = 1'b0; for (int i = 0; i < 80; i++) tick();

    // constrained random mix
    tag = "R2";
    for (int ln = 0; ln < 60; ln++) begin
      int p, n, sel;
      p = 20 + int'($urandom % 281);
      sel = int'($urandom % 6);
      n = (sel == 0) ? 1 + int'($urandom % p) : ((sel == 1) ? 2 * p + 3 : p);
      line_period = 12'(p); duty_code = 8'($urandom); phase_code = 8'($urandom);
      line_strobe = 1'b1;
      for (int i = 0; i < n; i++) begin
        drive_en_n = ($urandom % 50) == 0;
        uv_flag    = ($urandom % 50) == 0;
        if (($urandom % 40) == 0) begin
          duty_code = 8'($urandom); phase_code = 8'($urandom);
        end
        tick();
        line_strobe = 1'b0;
      end
    end
    drive_en_n = 1'b0; uv_flag = 1'b0;

    // R10: overvoltage latch, then cleared only by reset
    tag = "R10"; run_line(100, 128, 38, 10);
    ov_flag = 1'b1; tick(); ov_flag = 1'b0;
    for (int i = 0; i < 250; i++) begin
      line_strobe = (i % 100) == 0;
      tick();
    end
    line_strobe = 1'b0;
    tag = "R1"; rst_n = 1'b0; tick(); tick(); rst_n = 1'b1; tick();
    tag = "R2"; run_line(100, 128, 38, 200);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule